// File: doc/BRIEF.md
# Banked scratchpad conflict serializer

This block serves one warp-wide scratchpad access at a time. A request carries one word address per lane, a per-lane active bit and a load/store flag; for stores it also carries one data word per lane. The scratchpad inside the block is split into word-interleaved banks, so the low bits of a word address select the bank and the upper bits select the row inside it. Each clock cycle, every bank serves one word. The block therefore repeats bank-access rounds until every active lane has been served.

In each round, a bank picks the word named by its lowest-numbered pending lane. Every pending lane that names that same word is served in the same round, so identical addresses are broadcast and do not cost an extra round. Lanes that name other words in that bank wait for a later round. The number of rounds for a request is the largest count of distinct words that fall into any one bank. After the last round, the block presents the per-lane load data on a single response beat.

Requests enter through a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a cycle with both `req_valid` and `req_ready` high. The block does not take a new request until the consumer has taken the current response. The response is valid/ready as well: `resp_valid` and `resp_data` stay held while `resp_ready` is low, which is how back-pressure reaches the request side.

Top module: `spad_conflict_serializer`

## Requirements
- R1: Word address w lives in bank w mod BANKS (bank = low log2(BANKS) address bits). Lanes that address different banks are served in the same round, so a stride-1 access over all lanes takes one round.
- R2: Distinct words in the same bank are served in separate rounds. The number of rounds equals the largest count of distinct active words in any one bank: stride 2 takes two rounds, and a column of an unpadded 32-word-pitch tile takes 32 rounds.
- R3: Active lanes that name the identical word are all served in the same round with that word's data, and they add no round: all lanes on one address take one round.
- R4: A column access over a tile with a row pitch of 33 words (lane i at i*33+c) takes one round.
- R5: Inactive lanes add no round and return zero data. A request with no active lane completes in one cycle with all data zero.
- R6: `req_ready` is high only when the block is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. From acceptance until the response has been taken, `req_ready` stays low.
- R7: While `resp_valid` is high and `resp_ready` is low, `resp_valid` stays high and `resp_data` does not change. The response is taken on an edge with both high.
- R8: `resp_valid` first reads high N clock edges after the accepting edge, where N = max(1, number of rounds).
- R9: A store (`req_write`=1) writes each active lane's word into its bank. When several active lanes store to one word, the value from the lowest-numbered of them is kept. A store returns all-zero response data.
- R10: After reset, `req_ready` is 1 and `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_active | input | LANES | Per-lane active bits |
| req_addr | input | LANES*ADDR_W | Per-lane word addresses, lane l at bits [l*ADDR_W +: ADDR_W] |
| req_wdata | input | LANES*DATA_W | Per-lane store data |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_data | output | LANES*DATA_W | Per-lane load data, zero for inactive lanes and for stores |

## Verification
The assertions assume the environment never drops `req_valid` on its own account. They also assume reads address only words that were stored earlier, so the response data is never undefined. The bench loads the whole scratchpad with stride-1 stores before it issues any load. It then holds each request until it is accepted and changes the request inputs only while `req_ready` is low or `req_valid` is low. It applies back-pressure only by holding `resp_ready` low, and that is the only condition under which the stall assertions are active.

// File: rtl/scs_pkg.sv
package scs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } scs_state_e;

endpackage

// File: rtl/scs_bank_pick.sv
// Per-bank round selector: picks the word of the lowest pending lane that
// maps to this bank and marks every pending lane naming that same word.
module scs_bank_pick #(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 10,
  parameter int BANK_W  = 5,
  parameter int BANK_ID = 0,
  localparam int LANE_W = $clog2(LANES),
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  logic [LANES-1:0]             pending,
  input  logic [LANES-1:0][ADDR_W-1:0] addr,
  output logic                         hit,
  output logic [LANE_W-1:0]            lead_lane,
  output logic [ROW_W-1:0]             lead_row,
  output logic [LANES-1:0]             serve
);

  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  logic [ADDR_W-1:0] lead_addr;

  always_comb begin
    hit       = 1'b0;
    lead_lane = '0;
    lead_addr = '0;
    // descending scan: the lowest matching lane is the last one written
    for (int l = LANES - 1; l >= 0; l--) begin
      if (pending[l] && (addr[l][BANK_W-1:0] == MY_BANK)) begin
        hit       = 1'b1;
        lead_lane = LANE_W'(l);
        lead_addr = addr[l];
      end
    end
    for (int l = 0; l < LANES; l++) begin
      serve[l] = hit && pending[l] && (addr[l] == lead_addr);
    end
  end

  assign lead_row = lead_addr[ADDR_W-1:BANK_W];

endmodule

// File: rtl/scs_bank_ram.sv
// One scratchpad bank: write on the clock edge, read combinationally.
module scs_bank_ram #(
  parameter int ROW_W  = 5,
  parameter int DATA_W = 32,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
  end

  assign rdata = mem[row];

endmodule

// File: rtl/scs_seq_ctrl.sv
// Request/round/response sequencer.
module scs_seq_ctrl
  import scs_pkg::*;
#(
  parameter int LANES = 32,
  localparam int CNT_W = $clog2(LANES + 1) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic resp_ready,
  input  logic last_round,
  output logic req_ready,
  output logic resp_valid,
  output logic accept,
  output logic running
);

  scs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid)  state_d = ST_RUN;
      ST_RUN:  if (last_round) state_d = ST_DONE;
      ST_DONE: if (resp_ready) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign resp_valid = (state_q == ST_DONE);
  assign running    = (state_q == ST_RUN);
  assign accept     = req_valid && req_ready;

  // round counter used only by the bound check below
  logic [CNT_W-1:0] run_cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       run_cnt_q <= '0;
    else if (running) run_cnt_q <= run_cnt_q + 1'b1;
    else              run_cnt_q <= '0;
  end

  // R6
  resp_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);

  // R7
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid);

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R2
  round_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> run_cnt_q < CNT_W'(LANES));

endmodule

// File: rtl/spad_conflict_serializer.sv
module spad_conflict_serializer
  import scs_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [LANES-1:0]             req_active,
  input  logic [LANES-1:0][ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0][DATA_W-1:0] req_wdata,
  output logic                         resp_valid,
  input  logic                         resp_ready,
  output logic [LANES-1:0][DATA_W-1:0] resp_data
);

  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int LANE_W = $clog2(LANES);

  logic                         accept, running, last_round;
  logic [LANES-1:0]             pending_q, act_q, serve_all;
  logic                         wr_q;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0][DATA_W-1:0] wdata_q;
  logic [LANES-1:0][DATA_W-1:0] rdata_q;

  logic [BANKS-1:0]  bank_hit;
  logic [LANES-1:0]  bank_serve [BANKS];
  logic [LANE_W-1:0] bank_lead  [BANKS];
  logic [ROW_W-1:0]  bank_row   [BANKS];
  logic [DATA_W-1:0] bank_rd    [BANKS];

  scs_seq_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .resp_ready(resp_ready),
    .last_round(last_round),
    .req_ready (req_ready),
    .resp_valid(resp_valid),
    .accept    (accept),
    .running   (running)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    scs_bank_pick #(
      .LANES  (LANES),
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W),
      .BANK_ID(b)
    ) u_pick (
      .pending  (pending_q),
      .addr     (addr_q),
      .hit      (bank_hit[b]),
      .lead_lane(bank_lead[b]),
      .lead_row (bank_row[b]),
      .serve    (bank_serve[b])
    );

    scs_bank_ram #(
      .ROW_W (ROW_W),
      .DATA_W(DATA_W)
    ) u_ram (
      .clk  (clk),
      .we   (running && wr_q && bank_hit[b]),
      .row  (bank_row[b]),
      .wdata(wdata_q[bank_lead[b]]),
      .rdata(bank_rd[b])
    );
  end

  always_comb begin
    serve_all = '0;
    for (int b = 0; b < BANKS; b++) serve_all = serve_all | bank_serve[b];
  end

  assign last_round = ((pending_q & ~serve_all) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= '0;
      act_q     <= '0;
      wr_q      <= 1'b0;
      rdata_q   <= '0;
    end else if (accept) begin
      pending_q <= req_active;
      act_q     <= req_active;
      wr_q      <= req_write;
      rdata_q   <= '0;
    end else if (running) begin
      pending_q <= pending_q & ~serve_all;
      for (int l = 0; l < LANES; l++) begin
        if (serve_all[l] && !wr_q) rdata_q[l] <= bank_rd[addr_q[l][BANK_W-1:0]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign resp_data = rdata_q;

  // R2
  round_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && (pending_q != '0) |=>
      $countones(pending_q) < $past($countones(pending_q)));

  // R5
  served_were_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ((serve_all & ~pending_q) == '0));

  // R7
  resp_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> $stable(resp_data));

  // R9
  store_resp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && wr_q |-> (resp_data == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // R5
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !act_q[l] |-> (resp_data[l] == '0));
  end

endmodule

// File: tb/spad_conflict_serializer_tb.sv
module spad_conflict_serializer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int L  = 32;
  localparam int NB = 32;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int WORDS = 1 << AW;

  typedef logic [L-1:0][AW-1:0] addr_v;
  typedef logic [L-1:0][DW-1:0] data_v;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, resp_ready = 1'b1;
  logic [L-1:0] req_active = '0;
  addr_v req_addr = '0;
  data_v req_wdata = '0;
  logic req_ready, resp_valid;
  data_v resp_data;

  spad_conflict_serializer #(.LANES(L), .BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_active(req_active), .req_addr(req_addr),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic [DW-1:0] mdl [WORDS];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R8: actual=run not finished expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a) * 32'h9E37_79B1 + 32'h0135_7BDF;
  endfunction

  // issue one request, count rounds, compare data against the model
  task automatic run_req(input bit wr, input logic [L-1:0] act, input addr_v a,
                         input data_v wd, input int exp_n, input int stall,
                         input string rq_n, input string rq_d);
    int cyc;
    data_v exp_d, snap;
    bit bad;
    int bad_l;
    @(negedge clk);
    resp_ready = (stall == 0);
    req_valid  = 1'b1;
    req_write  = wr;
    req_active = act;
    req_addr   = a;
    req_wdata  = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R6", "ready low after accept", 64'(req_ready), 0);
    cyc = 0;
    while (!resp_valid && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == exp_n, rq_n, "round count", 64'(cyc), 64'(exp_n));
    for (int l = 0; l < L; l++)
      exp_d[l] = (act[l] && !wr) ? mdl[a[l]] : '0;
    bad = 1'b0;
    bad_l = 0;
    for (int l = 0; l < L; l++)
      if (!bad && resp_data[l] !== exp_d[l]) begin bad = 1'b1; bad_l = l; end
    check(!bad, rq_d, $sformatf("lane %0d data", bad_l),
          64'(resp_data[bad_l]), 64'(exp_d[bad_l]));
    snap = resp_data;
    if (stall > 0) begin
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        check(resp_valid && !req_ready, "R7", "valid held under stall",
              64'({resp_valid, req_ready}), 64'b10);
        check(resp_data == snap, "R7", "data stable under stall",
              64'(resp_data[0]), 64'(snap[0]));
      end
      resp_ready = 1'b1;
      @(negedge clk);
      check(!resp_valid && req_ready, "R7", "taken after ready",
            64'({resp_valid, req_ready}), 64'b01);
    end
    if (wr)
      for (int l = L - 1; l >= 0; l--)
        if (act[l]) mdl[a[l]] = wd[l];
  endtask

  task automatic t_reset;
    // R10
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "req_ready after reset", 64'(req_ready), 1);
    check(resp_valid == 1'b0, "R10", "resp_valid after reset", 64'(resp_valid), 0);
  endtask

  task automatic t_fill;
    // R1, R9: stride-1 stores cover the whole scratchpad, one round each
    addr_v a;
    data_v d;
    for (int k = 0; k < WORDS / L; k++) begin
      for (int l = 0; l < L; l++) begin
        a[l] = AW'(k * L + l);
        d[l] = pat(k * L + l);
      end
      run_req(1'b1, '1, a, d, 1, 0, "R1", "R9");
    end
  endtask

  task automatic t_stride1;
    // R1
    addr_v a;
    for (int l = 0; l < L; l++) a[l] = AW'(200 + l);
    run_req(1'b0, '1, a, '0, 1, 0, "R1/R8", "R1");
  endtask

  task automatic t_stride2;
    // R2
    addr_v a;
    for (int l = 0; l < L; l++) a[l] = AW'(2 * l);
    run_req(1'b0, '1, a, '0, 2, 0, "R2/R8", "R2");
  endtask

  task automatic t_broadcast;
    // R3
    addr_v a;
    for (int l = 0; l < L; l++) a[l] = AW'(77);
    run_req(1'b0, '1, a, '0, 1, 0, "R3", "R3");
  endtask

  task automatic t_columns;
    // R4 padded pitch, R2 unpadded pitch
    addr_v a;
    for (int l = 0; l < L; l++) a[l] = AW'(l * 33 + 5);
    run_req(1'b0, '1, a, '0, 1, 0, "R4", "R4");
    for (int l = 0; l < L; l++) a[l] = AW'(l * 32 + 5);
    run_req(1'b0, '1, a, '0, 32, 0, "R2", "R2");
  endtask

  task automatic t_inactive;
    // R5
    addr_v a;
    for (int l = 0; l < L; l++) a[l] = AW'(2 * l);
    run_req(1'b0, 32'h0000_FFFF, a, '0, 1, 0, "R5", "R5");
    run_req(1'b0, '0, a, '0, 1, 0, "R5/R8", "R5");
  endtask

  task automatic t_mixed;
    // R2, R3: bank 5 holds words 5, 37, 69 (lane 2 repeats word 5)
    addr_v a;
    for (int l = 0; l < L; l++) a[l] = AW'(100 + l);
    a[0] = AW'(5);
    a[1] = AW'(37);
    a[2] = AW'(5);
    a[3] = AW'(69);
    run_req(1'b0, '1, a, '0, 3, 0, "R2/R8", "R3");
  endtask

  task automatic t_store_conflict;
    // R9: lanes 1..31 store word 7, lane 1 (lowest active) must win
    addr_v a;
    data_v d;
    for (int l = 0; l < L; l++) begin
      a[l] = AW'(7);
      d[l] = 32'hC0DE_0000 + DW'(l);
    end
    run_req(1'b1, 32'hFFFF_FFFE, a, d, 1, 0, "R9", "R9");
    check(mdl[7] == 32'hC0DE_0001, "R9", "model lowest lane", 64'(mdl[7]), 64'h C0DE_0001);
    run_req(1'b0, 32'h0000_0001, a, '0, 1, 0, "R9", "R9");
  endtask

  task automatic t_backpressure;
    // R6, R7
    addr_v a;
    for (int l = 0; l < L; l++) a[l] = AW'(3 * l);
    run_req(1'b0, '1, a, '0, 1, 5, "R1", "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_stride1();
    t_stride2();
    t_broadcast();
    t_columns();
    t_inactive();
    t_mixed();
    t_store_conflict();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule